// File: doc/BRIEF.md
# Interrupt Redirection Controller for a PCI Host Bridge

This block collects the level interrupt lines of a PCI host bridge and turns each new assertion into one outbound message write. The message carries an interrupt vector and goes to a destination address. Software programs the block indirectly. It first writes an index into a select register. It then reads or writes the table word at that index through a data window. Each input owns two words in the table. The low word holds the vector and the control bits. The high word holds the destination address in a byte-swapped packed form.

A pending bitmap records which vectors are in service. A message is sent only when a pending bit goes from 0 to 1. Software retires an interrupt by writing its vector to the end-of-interrupt register. The block then clears the pending bit of every input programmed with that vector. If the line is still high, the interrupt fires again.

Top module: `intr_redirect`

## Requirements
- R1: Writing offset 0x800 loads the 32-bit index register, and reading 0x800 returns it. At offset 0x810, reads and writes reach table word `index` of the 32-word table. A read from any offset other than 0x800 and 0x810 returns 0.
- R2: When the index is 1, a window read returns the version word 0x00200001 (table size 32 in bits 31:16, value 1 in bits 15:0). A window write at index 1 changes nothing.
- R3: When the index is 32 or more, a window write is ignored and a window read returns 0xFFFFFFFF.
- R4: After reset the pending bitmap is 0, the index is 0, no message is offered, and every table word is 0 except the redirection words. For input i, the low word at 0x10+2i resets to 0x0001A000 | (i+2): bit 16 (mask), bit 15 (level) and bit 13 (active low) are set. The high word at 0x11+2i resets to 0xA0FF0000, which is the packed form of destination 0xFFFA0000.
- R5: An input is active when its line is high, bit 16 of its low word is 0, and bits 31:16 of its high word are nonzero. On the next clock an active input sets pending bit (low word bits 1:0).
- R6: An active input whose pending bit was 0 queues one message. The message data is low word bits 5:0. The message address has bits 31:28 = 0xF, bits 27:20 = high word bits 23:16, bits 19:12 = high word bits 31:24, and bits 11:0 = 0. While the pending bit stays set, no further message is sent.
- R7: An input that is not active clears its pending bit on the next clock, unless another active input sets that same bit.
- R8: A write to offset 0x840 takes data bits 5:0 as a vector and clears the pending bit of every input whose low word bits 5:0 equal that vector. This clear wins over a set in the same cycle, so an input that is still active sets the bit again one clock later and sends a new message.
- R9: `msg_valid` stays high until `msg_ready` accepts the message. Each input holds at most one queued message, and a trigger that arrives while its message is still queued is dropped.
- R10: When several inputs have queued messages, the lowest-numbered input is offered first.
- R11: Low-word bits 15, 13 and 8 are stored and read back but do not change when an input triggers. The line is always taken as active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 4 | Interrupt lines, one per input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| msg_valid | output | 1 | Outbound message offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_addr | output | 32 | Message destination address |
| msg_data | output | 6 | Message vector |
| pend_o | output | 4 | Pending bitmap |

## Verification
The assertions assume that the receiver does not drop `msg_ready` handling in a way that changes a message already offered. They also assume that the interrupt lines and the register strobe change only between clock edges. The bench drives every input on the falling edge and samples on the next falling edge. It raises and lowers lines only when the expected pending and queue state is known. It keeps all lines low during the random table-access phase, so random writes to the redirection words cannot start an interrupt.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_SEL = 12'h800;
  localparam logic [ADDR_W-1:0] OFF_WIN = 12'h810;
  localparam logic [ADDR_W-1:0] OFF_EOI = 12'h840;
  localparam int VER_IDX   = 1;
  localparam int MASK_BIT  = 16;
  localparam int LEVEL_BIT = 15;
  localparam int POLLO_BIT = 13;
  localparam int VEC_W     = 6;

  // packed destination field (high word bits 31:16) -> message address
  function automatic logic [31:0] dest_from_field(logic [15:0] f);
    return {4'hF, f[7:0], f[15:8], 12'h000};
  endfunction

  // destination address -> packed high word
  function automatic logic [31:0] pack_dest(logic [31:0] a);
    return {a[19:12], a[27:20], 16'h0000};
  endfunction

  function automatic logic [31:0] version_word(int entries);
    return {16'(entries), 16'h0001};
  endfunction
endpackage

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int TBL_DEPTH = 32,
  parameter int RTE_BASE  = 16,
  parameter logic [31:0] CPU_ADDR = 32'hFFFA0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic [NUM_IN-1:0]            lo_mask,
  output logic [NUM_IN-1:0][VEC_W-1:0] lo_vec,
  output logic [NUM_IN-1:0][15:0]      hi_field
);
  localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;

  logic [31:0] sel_q;
  logic [31:0] tbl_q [TBL_DEPTH];
  logic        sel_ok, sel_ver, sel_wr, win_wr;
  logic [IDX_W-1:0] sel_idx;

  function automatic logic [31:0] rte_default(int e);
    int off;
    off = e - RTE_BASE;
    if (e >= RTE_BASE && e < RTE_BASE + 2 * NUM_IN) begin
      if (off % 2 == 0)
        return (32'd1 << MASK_BIT) | (32'd1 << LEVEL_BIT) |
               (32'd1 << POLLO_BIT) | 32'(off / 2 + 2);
      else
        return pack_dest(CPU_ADDR);
    end
    return 32'h0;
  endfunction

  assign sel_ok  = sel_q < 32'(TBL_DEPTH);
  assign sel_ver = sel_q == 32'(VER_IDX);
  assign sel_idx = sel_q[IDX_W-1:0];
  assign sel_wr  = reg_wr && (reg_addr == OFF_SEL);
  assign win_wr  = reg_wr && (reg_addr == OFF_WIN) && sel_ok && !sel_ver;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int e = 0; e < TBL_DEPTH; e++) tbl_q[e] <= rte_default(e);
    end else begin
      if (sel_wr) sel_q <= reg_wdata;
      if (win_wr) tbl_q[sel_idx] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_SEL) reg_rdata = sel_q;
    else if (reg_addr == OFF_WIN) begin
      if (sel_ver)     reg_rdata = version_word(TBL_DEPTH);
      else if (sel_ok) reg_rdata = tbl_q[sel_idx];
      else             reg_rdata = '1;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_fields
    assign lo_mask[i]  = tbl_q[RTE_BASE + 2*i][MASK_BIT];
    assign lo_vec[i]   = tbl_q[RTE_BASE + 2*i][VEC_W-1:0];
    assign hi_field[i] = tbl_q[RTE_BASE + 2*i + 1][31:16];
  end
endmodule

// File: rtl/irc_pend.sv
module irc_pend
  import irc_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_IN-1:0]            irq_in,
  input  logic [NUM_IN-1:0]            lo_mask,
  input  logic [NUM_IN-1:0][VEC_W-1:0] lo_vec,
  input  logic [NUM_IN-1:0][15:0]      hi_field,
  input  logic                         eoi_wr,
  input  logic [VEC_W-1:0]             eoi_vec,
  output logic [NUM_IN-1:0]            pend_o,
  output logic [NUM_IN-1:0]            fire
);
  localparam int BIT_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [NUM_IN-1:0] pend_q, set_v, low_clr, eoi_clr, act;
  logic [BIT_W-1:0]  pos [NUM_IN];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assign pos[i]  = lo_vec[i][BIT_W-1:0];
    assign act[i]  = irq_in[i] && !lo_mask[i] && (|hi_field[i]);
    assign fire[i] = act[i] && !pend_q[pos[i]];
  end

  always_comb begin
    set_v = '0; low_clr = '0; eoi_clr = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (act[i]) set_v[pos[i]] = 1'b1;
      else        low_clr[pos[i]] = 1'b1;
      if (eoi_wr && lo_vec[i] == eoi_vec) eoi_clr[pos[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= ((pend_q & ~low_clr) | set_v) & ~eoi_clr;
  end

  assign pend_o = pend_q;

  for (genvar b = 0; b < NUM_IN; b++) begin : g_chk
    AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_clr[b] |=> !pend_q[b]);                                   // R8
    AST_SET_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v[b] && !eoi_clr[b]) |=> pend_q[b]);                     // R5
  end
endmodule

// File: rtl/irc_msgq.sv
module irc_msgq
  import irc_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_IN-1:0]            fire,
  input  logic [NUM_IN-1:0][31:0]      fire_addr,
  input  logic [NUM_IN-1:0][VEC_W-1:0] fire_data,
  input  logic                         msg_ready,
  output logic                         msg_valid,
  output logic [31:0]                  msg_addr,
  output logic [VEC_W-1:0]             msg_data
);
  logic [NUM_IN-1:0]            slot_v, grant, drain;
  logic [NUM_IN-1:0][31:0]      slot_addr;
  logic [NUM_IN-1:0][VEC_W-1:0] slot_data;

  always_comb begin
    logic found;
    found = 1'b0; grant = '0; msg_addr = '0; msg_data = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (slot_v[i] && !found) begin
        grant[i] = 1'b1; found = 1'b1;
        msg_addr = slot_addr[i]; msg_data = slot_data[i];
      end
    end
  end

  assign msg_valid = |slot_v;
  assign drain     = grant & {NUM_IN{msg_ready}};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_v[i]    <= 1'b0;
        slot_addr[i] <= '0;
        slot_data[i] <= '0;
      end else if (fire[i] && (!slot_v[i] || drain[i])) begin
        slot_v[i]    <= 1'b1;
        slot_addr[i] <= fire_addr[i];
        slot_data[i] <= fire_data[i];
      end else if (drain[i]) begin
        slot_v[i] <= 1'b0;
      end
    end
    AST_FIRE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> slot_v[i]);                                       // R9
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));                                               // R10
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);                       // R9
endmodule

// File: rtl/intr_redirect.sv
module intr_redirect
  import irc_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int TBL_DEPTH = 32,
  parameter int RTE_BASE  = 16,
  parameter logic [31:0] CPU_ADDR = 32'hFFFA0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IN-1:0]  irq_in,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [31:0]        msg_addr,
  output logic [VEC_W-1:0]   msg_data,
  output logic [NUM_IN-1:0]  pend_o
);
  logic [NUM_IN-1:0]            lo_mask, fire;
  logic [NUM_IN-1:0][VEC_W-1:0] lo_vec;
  logic [NUM_IN-1:0][15:0]      hi_field;
  logic [NUM_IN-1:0][31:0]      fire_addr;
  logic                         eoi_wr;

  assign eoi_wr = reg_wr && (reg_addr == OFF_EOI);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_dest
    assign fire_addr[i] = dest_from_field(hi_field[i]);
  end

  irc_regs #(.NUM_IN(NUM_IN), .TBL_DEPTH(TBL_DEPTH), .RTE_BASE(RTE_BASE),
             .CPU_ADDR(CPU_ADDR)) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_mask(lo_mask),
    .lo_vec(lo_vec), .hi_field(hi_field));

  irc_pend #(.NUM_IN(NUM_IN)) i_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lo_mask(lo_mask),
    .lo_vec(lo_vec), .hi_field(hi_field), .eoi_wr(eoi_wr),
    .eoi_vec(reg_wdata[VEC_W-1:0]), .pend_o(pend_o), .fire(fire));

  irc_msgq #(.NUM_IN(NUM_IN)) i_msgq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_addr(fire_addr),
    .fire_data(lo_vec), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data));

  AST_MSG_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[31:28] == 4'hF && msg_addr[11:0] == 12'h0)); // R6
endmodule

// File: tb/test_intr_redirect.sv
module test_intr_redirect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq = '0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [5:0]  msg_data;
  logic [3:0]  pend_o;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  intr_redirect i_intr_redirect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .pend_o(pend_o));

  function automatic logic [31:0] exp_addr(logic [31:0] hi);
    logic [31:0] a;
    a = 32'hF000_0000;
    a[27:20] = hi[23:16];
    a[19:12] = hi[31:24];
    return a;
  endfunction

  function automatic logic [31:0] exp_pack(logic [31:0] a);
    logic [31:0] h;
    h = '0;
    h[23:16] = a[27:20];
    h[31:24] = a[19:12];
    return h;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wsel(int idx, logic [31:0] d);
    wr(12'h800, 32'(idx));
    wr(12'h810, d);
  endtask

  task automatic rdw(int idx, output logic [31:0] v);
    wr(12'h800, 32'(idx));
    reg_addr = 12'h810;
    #1 v = reg_rdata;
  endtask

  task automatic accept();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, model [32];
    int unsigned seed_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    chk("R4 pending", 32'(pend_o), 32'h0);
    chk("R4 valid", 32'(msg_valid), 32'h0);
    reg_addr = 12'h800; #1 chk("R4 select", reg_rdata, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rdw(16 + 2*i, v); chk("R4 low word", v, 32'h0001_A000 | 32'(i + 2));
      rdw(17 + 2*i, v); chk("R4 high word", v, exp_pack(32'hFFFA0000));
    end

    // R1 table write/read
    wsel(16, 32'h5);
    rdw(16, v); chk("R1 readback", v, 32'h5);
    reg_addr = 12'h800; #1 chk("R1 select read", reg_rdata, 32'd16);
    reg_addr = 12'h123; #1 chk("R1 other offset", reg_rdata, 32'h0);

    // R5/R6 trigger input 0, vector 5 -> pending bit 1
    irq = 4'b0001; @(negedge clk);
    chk("R5 pending set", 32'(pend_o), 32'h2);
    chk("R6 valid", 32'(msg_valid), 32'h1);
    chk("R6 addr", msg_addr, exp_addr(exp_pack(32'hFFFA0000)));
    chk("R6 data", 32'(msg_data), 32'h5);
    repeat (3) @(negedge clk);
    chk("R9 hold", 32'(msg_valid), 32'h1);
    accept();
    chk("R9 accepted", 32'(msg_valid), 32'h0);
    repeat (2) @(negedge clk);
    chk("R6 no repeat", 32'(msg_valid), 32'h0);

    // R8 EOI with line still high
    wr(12'h840, 32'hFFFF_FFC5);
    chk("R8 eoi cleared", 32'(pend_o), 32'h0);
    chk("R8 no msg yet", 32'(msg_valid), 32'h0);
    @(negedge clk);
    chk("R8 reset pend", 32'(pend_o), 32'h2);
    chk("R8 refire", 32'(msg_valid), 32'h1);
    accept();

    // R7 line low clears; R9 drop while queued
    irq = 4'b0000; @(negedge clk);
    chk("R7 low clears", 32'(pend_o), 32'h0);
    irq = 4'b0001; @(negedge clk);
    chk("R9 queued", 32'(msg_valid), 32'h1);
    irq = 4'b0000; @(negedge clk);
    irq = 4'b0001; @(negedge clk);
    accept();
    chk("R9 second dropped", 32'(msg_valid), 32'h0);

    // R7 masking while pending
    wsel(16, 32'h0001_0005);
    chk("R7 pend before mask seen", 32'(pend_o), 32'h2);
    @(negedge clk);
    chk("R7 masked clears", 32'(pend_o), 32'h0);
    irq = 4'b0000; @(negedge clk);

    // R5 masked input by default
    irq = 4'b0010; @(negedge clk);
    chk("R5 masked no pend", 32'(pend_o), 32'h0);
    chk("R5 masked no msg", 32'(msg_valid), 32'h0);
    irq = 4'b0000;

    // R5 zero destination, then R6 custom destination
    wsel(20, 32'h6);
    wsel(21, 32'h0);
    irq = 4'b0100; @(negedge clk);
    chk("R5 zero dest no pend", 32'(pend_o), 32'h0);
    chk("R5 zero dest no msg", 32'(msg_valid), 32'h0);
    wsel(21, 32'h1234_0000);
    @(negedge clk);
    chk("R5 dest pend", 32'(pend_o), 32'h4);
    chk("R6 custom addr", msg_addr, exp_addr(32'h1234_0000));
    chk("R6 custom data", 32'(msg_data), 32'h6);
    accept();
    irq = 4'b0000; @(negedge clk);

    // R10 priority
    wsel(22, 32'h7);
    irq = 4'b1100; @(negedge clk);
    chk("R10 pend both", 32'(pend_o), 32'hC);
    chk("R10 first is input 2", 32'(msg_data), 32'h6);
    accept();
    chk("R10 then input 3 valid", 32'(msg_valid), 32'h1);
    chk("R10 then input 3 data", 32'(msg_data), 32'h7);
    chk("R10 input 3 addr", msg_addr, exp_addr(exp_pack(32'hFFFA0000)));
    accept();
    chk("R10 drained", 32'(msg_valid), 32'h0);
    irq = 4'b0000; @(negedge clk);

    // R11 control bits do not alter triggering
    wsel(18, 32'h0000_A109);
    rdw(18, v); chk("R11 readback", v, 32'h0000_A109);
    irq = 4'b0010; @(negedge clk);
    chk("R11 pend", 32'(pend_o), 32'h2);
    chk("R11 msg data", 32'(msg_data), 32'h9);
    accept();
    irq = 4'b0000; @(negedge clk);

    // R2 version word
    rdw(1, v); chk("R2 version", v, 32'h0020_0001);
    wsel(1, 32'hDEAD_BEEF);
    rdw(1, v); chk("R2 write ignored", v, 32'h0020_0001);

    // R3 out of range
    wsel(40, 32'h1111_2222);
    rdw(40, v); chk("R3 read ones", v, 32'hFFFF_FFFF);
    rdw(32, v); chk("R3 edge index", v, 32'hFFFF_FFFF);
    rdw(8, v);  chk("R3 no alias", v, 32'h0);

    // R1/R3 random table traffic, all lines low
    seed_v = $urandom(32'd1234);
    for (int e = 0; e < 32; e++) begin
      if (e != 1) begin
        v = $urandom; wsel(e, v); model[e] = v;
      end
    end
    model[1] = 32'h0020_0001;
    for (int n = 0; n < 150; n++) begin
      int idx, ridx;
      logic [31:0] d, r, exp_v;
      idx = int'($urandom_range(0, 39));
      d = $urandom;
      wsel(idx, d);
      if (idx < 32 && idx != 1) model[idx] = d;
      ridx = int'($urandom_range(0, 39));
      rdw(ridx, r);
      exp_v = (ridx >= 32) ? 32'hFFFF_FFFF : model[ridx];
      chk("R1 R3 random", r, exp_v);
    end
    @(negedge clk);
    chk("R5 idle lines no pend", 32'(pend_o), 32'h0);
    finish_run();
  end
endmodule